// File: doc/BRIEF.md
# MI Coherence Line Controller

This block is the L1-side controller of a two-state (modified / invalid) coherence protocol. It keeps a small, directly indexed table of lines. Each entry holds an address tag and a protocol state. The controller takes processor requests (load, instruction fetch, store) and messages from the interconnect (fill data, a forwarded exclusive request, an invalidation, and a positive or negative writeback acknowledgement). For each one it decides the next state of the line and the outbound message, if any. The outbound messages are an exclusive-ownership request, a writeback, and a data reply.

A processor request stays on the processor port until it completes. It completes only when its line is in M with a matching tag. A request to an empty line issues an exclusive request and leaves the line waiting for data. A request whose index is occupied by a modified line with a different tag first evicts that victim line with a writeback. A request to a line in any waiting state is stalled without any change. Only one event is handled per cycle, and the interconnect has priority. All effects of an event take place at a single clock edge. Outbound messages reach the outbound port after a fixed issue latency.

Line states: I (invalid), M (modified), and the busy transient states IS (load or fetch issued), IM (store issued), MI (writeback issued), II (writeback issued after the data was given away) and MII (writeback refused). Transitions: I-Load/Ifetch→IS, I-Store→IM, IS/IM-Data→M, M-Replacement→MI, M-Fwd/Inv→I, MI-Ack→I, MI-Nack→MII, MI-Fwd/Inv→II, II-Ack/Nack→I, MII-Fwd/Inv→I.

Top module: `mi_line_ctrl`

## Requirements
- R1: After reset every line is I, `perm` reads 0 for any address, `out_valid`, `cpu_ready` and `proto_err` are 0.
- R2: `perm` for `perm_addr` (index = low IDX_W bits, tag = the rest) is 2 when that line is M with the same tag, 1 when it is IS, IM, MI, II or MII with the same tag, and 0 otherwise.
- R3: A request to a line in I allocates the requested tag, sends GETX with the request address to DIR_ID, and moves the line to IM for a store (`cpu_op` 2) or to IS for a load (0), fetch (1) or code 3 (treated as load). `cpu_ready` stays 0.
- R4: Data (`net_type` 0) for a line in IS or IM with the same tag moves it to M. A processor request to a line in M with a matching tag gets `cpu_ready`=1 in that same cycle and changes no state.
- R5: A request whose index holds a line in M with another tag raises a replacement on that victim: a PUT carrying the victim address is sent to DIR_ID, the victim goes to MI, and the request does not complete.
- R6: A request to a line in IS, IM, MI, II or MII is stalled: `cpu_ready` 0, no state change, no message.
- R7: In MI, writeback ack (`net_type` 3) → I, writeback nack (4) → MII, forwarded GETX (1) or invalidate (2) → II with a DATA reply. In II, ack or nack → I. In MII, forwarded GETX or invalidate → I with a DATA reply.
- R8: In M, a forwarded GETX or invalidate sends DATA to `net_src` and moves the line to I.
- R9: A message caused by an event accepted at clock edge k is on the outbound port after edge k+ISSUE_LAT-1, for one cycle. The encodings are `out_type` 1 GETX, 2 PUT, 3 DATA. `out_src` is REQ_ID, and `out_dest` is DIR_ID for GETX/PUT and `net_src` for DATA.
- R10: When `net_valid` is high the processor port is not serviced: `cpu_ready` is 0 and only the network event takes effect.
- R11: A network event that the line's state does not accept (including one aimed at a line that is not held with that tag) sets `proto_err`, which stays set until reset. The line state is unchanged and no message is sent.
- R12: `net_type` values 5 to 7 have no effect on state, messages or `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 fetch, 2 store, 3 as load |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_ready | output | 1 | Request completed this cycle (hit) |
| net_valid | input | 1 | Network message present |
| net_type | input | 3 | 0 data, 1 fwd GETX, 2 invalidate, 3 wb ack, 4 wb nack |
| net_addr | input | ADDR_W | Network message line address |
| net_src | input | NODE_W | Sender of the network message |
| perm_addr | input | ADDR_W | Address whose permission is reported |
| perm | output | 2 | 0 invalid, 1 busy, 2 read-write |
| out_valid | output | 1 | Outbound message valid |
| out_type | output | 2 | 1 GETX, 2 PUT, 3 DATA |
| out_addr | output | ADDR_W | Outbound message line address |
| out_src | output | NODE_W | Requester ID (REQ_ID) |
| out_dest | output | NODE_W | Destination node |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench targets these corner cases:
- A miss onto an index that a modified line already holds. A design that triggers the replacement on the requested address would write back the wrong line.
- Processor requests that arrive while their line is busy. A design that drops or re-issues them would send duplicate GETX messages or lose the request.
- A nacked writeback followed by a forwarded request, and a forward that races an outstanding writeback. A design that collapses MII or II into a stable state would reach the wrong final state or omit the data reply.
- Simultaneous processor and network traffic, which a design with the wrong priority would handle in the same cycle.

// File: rtl/mi_pkg.sv
package mi_pkg;

    typedef enum logic [2:0] {
        ST_I   = 3'd0,
        ST_II  = 3'd1,
        ST_M   = 3'd2,
        ST_MI  = 3'd3,
        ST_MII = 3'd4,
        ST_IS  = 3'd5,
        ST_IM  = 3'd6
    } line_st_t;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_LOAD,
        EV_IFETCH,
        EV_STORE,
        EV_DATA,
        EV_FWD_GETX,
        EV_INV,
        EV_REPL,
        EV_WB_ACK,
        EV_WB_NACK
    } event_t;

    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_GETX = 2'd1,
        MSG_PUT  = 2'd2,
        MSG_DATA = 2'd3
    } msg_t;

    typedef enum logic [1:0] {
        PERM_INVALID = 2'd0,
        PERM_BUSY    = 2'd1,
        PERM_RW      = 2'd2
    } perm_t;

    function automatic perm_t perm_of(line_st_t s);
        unique case (s)
            ST_I:    return PERM_INVALID;
            ST_M:    return PERM_RW;
            default: return PERM_BUSY;
        endcase
    endfunction

endpackage

// File: rtl/mi_line_table.sv
module mi_line_table #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_slot,
    input  logic [2:0]                    wr_state,
    input  logic                          wr_tag_en,
    input  logic [TAG_W-1:0]              wr_tag,
    output logic [NUM_LINES-1:0][2:0]     st_q,
    output logic [NUM_LINES-1:0][TAG_W-1:0] tag_q
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit_slot;
        assign hit_slot = (wr_slot == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= 3'(mi_pkg::ST_I);
                tag_q[g] <= '0;
            end else if (wr_en && hit_slot) begin
                st_q[g] <= wr_state;
                if (wr_tag_en) begin
                    tag_q[g] <= wr_tag;
                end
            end
        end
    end
endmodule

// File: rtl/mi_event_sel.sv
module mi_event_sel
    import mi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 6,
    parameter int IDX_W     = 2,
    parameter int NODE_W    = 3,
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                            cpu_valid,
    input  logic [1:0]                      cpu_op,
    input  logic [ADDR_W-1:0]               cpu_addr,
    input  logic                            net_valid,
    input  logic [2:0]                      net_type,
    input  logic [ADDR_W-1:0]               net_addr,
    input  logic [NODE_W-1:0]               net_src,
    input  logic [NUM_LINES-1:0][2:0]       st_q,
    input  logic [NUM_LINES-1:0][TAG_W-1:0] tag_q,
    output event_t                          ev,
    output line_st_t                        ev_state,
    output logic [IDX_W-1:0]                ev_slot,
    output logic [ADDR_W-1:0]               ev_addr,
    output logic [NODE_W-1:0]               ev_src,
    output logic                            ev_from_cpu
);
    line_st_t          cur;
    logic [TAG_W-1:0]  cur_tag;
    event_t            cpu_ev;

    always_comb begin
        unique case (cpu_op)
            2'd1:    cpu_ev = EV_IFETCH;
            2'd2:    cpu_ev = EV_STORE;
            default: cpu_ev = EV_LOAD;
        endcase
    end

    always_comb begin
        ev          = EV_NONE;
        ev_state    = ST_I;
        ev_slot     = '0;
        ev_addr     = '0;
        ev_src      = '0;
        ev_from_cpu = 1'b0;
        cur         = ST_I;
        cur_tag     = '0;
        if (net_valid) begin
            ev_slot = net_addr[IDX_W-1:0];
            ev_addr = net_addr;
            ev_src  = net_src;
            cur     = line_st_t'(st_q[ev_slot]);
            cur_tag = tag_q[ev_slot];
            ev_state = (cur_tag == net_addr[ADDR_W-1:IDX_W]) ? cur : ST_I;
            unique case (net_type)
                3'd0:    ev = EV_DATA;
                3'd1:    ev = EV_FWD_GETX;
                3'd2:    ev = EV_INV;
                3'd3:    ev = EV_WB_ACK;
                3'd4:    ev = EV_WB_NACK;
                default: ev = EV_NONE;
            endcase
        end else if (cpu_valid) begin
            ev_from_cpu = 1'b1;
            ev_slot = cpu_addr[IDX_W-1:0];
            ev_addr = cpu_addr;
            cur     = line_st_t'(st_q[ev_slot]);
            cur_tag = tag_q[ev_slot];
            ev      = cpu_ev;
            ev_state = cur;
            if (cur == ST_M && cur_tag != cpu_addr[ADDR_W-1:IDX_W]) begin
                ev      = EV_REPL;
                ev_addr = {cur_tag, ev_slot};
            end
        end
    end
endmodule

// File: rtl/mi_transition.sv
module mi_transition
    import mi_pkg::*;
(
    input  event_t   ev,
    input  line_st_t cur,
    output line_st_t nxt,
    output msg_t     send,
    output logic     hit,
    output logic     err
);
    logic is_cpu;
    logic is_fwd;
    assign is_cpu = (ev == EV_LOAD) || (ev == EV_IFETCH) || (ev == EV_STORE) || (ev == EV_REPL);
    assign is_fwd = (ev == EV_FWD_GETX) || (ev == EV_INV);

    always_comb begin
        nxt  = cur;
        send = MSG_NONE;
        hit  = 1'b0;
        err  = 1'b0;
        if (ev != EV_NONE) begin
            unique case (cur)
                ST_I: begin
                    if (ev == EV_LOAD || ev == EV_IFETCH) begin
                        nxt  = ST_IS;
                        send = MSG_GETX;
                    end else if (ev == EV_STORE) begin
                        nxt  = ST_IM;
                        send = MSG_GETX;
                    end else begin
                        err = 1'b1;
                    end
                end
                ST_IS, ST_IM: begin
                    if (ev == EV_DATA) begin
                        nxt = ST_M;
                    end else if (!is_cpu) begin
                        err = 1'b1;
                    end
                end
                ST_M: begin
                    if (ev == EV_REPL) begin
                        nxt  = ST_MI;
                        send = MSG_PUT;
                    end else if (is_cpu) begin
                        hit = 1'b1;
                    end else if (is_fwd) begin
                        nxt  = ST_I;
                        send = MSG_DATA;
                    end else begin
                        err = 1'b1;
                    end
                end
                ST_MI: begin
                    if (ev == EV_WB_ACK) begin
                        nxt = ST_I;
                    end else if (ev == EV_WB_NACK) begin
                        nxt = ST_MII;
                    end else if (is_fwd) begin
                        nxt  = ST_II;
                        send = MSG_DATA;
                    end else if (!is_cpu) begin
                        err = 1'b1;
                    end
                end
                ST_II: begin
                    if (ev == EV_WB_ACK || ev == EV_WB_NACK) begin
                        nxt = ST_I;
                    end else if (!is_cpu) begin
                        err = 1'b1;
                    end
                end
                ST_MII: begin
                    if (is_fwd) begin
                        nxt  = ST_I;
                        send = MSG_DATA;
                    end else if (!is_cpu) begin
                        err = 1'b1;
                    end
                end
                default: err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mi_msg_delay.sv
module mi_msg_delay #(
    parameter int LAT = 2,
    parameter int PW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] in_data,
    output logic          out_valid,
    output logic [PW-1:0] out_data
);
    logic [LAT-1:0]         v_q;
    logic [LAT-1:0][PW-1:0] d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[0] <= 1'b0;
            d_q[0] <= '0;
        end else begin
            v_q[0] <= in_valid;
            d_q[0] <= in_data;
        end
    end

    for (genvar g = 1; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[g] <= 1'b0;
                d_q[g] <= '0;
            end else begin
                v_q[g] <= v_q[g-1];
                d_q[g] <= d_q[g-1];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = d_q[LAT-1];
endmodule

// File: rtl/mi_line_ctrl.sv
module mi_line_ctrl
    import mi_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int IDX_W     = 2,
    parameter int NODE_W    = 3,
    parameter int ISSUE_LAT = 2,
    parameter int REQ_ID    = 1,
    parameter int DIR_ID    = 0,
    localparam int NUM_LINES = 1 << IDX_W,
    localparam int TAG_W     = ADDR_W - IDX_W,
    localparam int PW        = 2 + ADDR_W + NODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    input  logic              net_valid,
    input  logic [2:0]        net_type,
    input  logic [ADDR_W-1:0] net_addr,
    input  logic [NODE_W-1:0] net_src,
    input  logic [ADDR_W-1:0] perm_addr,
    output logic [1:0]        perm,
    output logic              out_valid,
    output logic [1:0]        out_type,
    output logic [ADDR_W-1:0] out_addr,
    output logic [NODE_W-1:0] out_src,
    output logic [NODE_W-1:0] out_dest,
    output logic              proto_err
);
    logic [NUM_LINES-1:0][2:0]       st_q;
    logic [NUM_LINES-1:0][TAG_W-1:0] tag_q;

    event_t            ev;
    line_st_t          ev_state;
    logic [IDX_W-1:0]  ev_slot;
    logic [ADDR_W-1:0] ev_addr;
    logic [NODE_W-1:0] ev_src;
    logic              ev_from_cpu;

    line_st_t tr_nxt;
    msg_t     tr_send;
    logic     tr_hit;
    logic     tr_err;

    logic              wr_en;
    logic              wr_tag_en;
    logic              msg_v;
    logic [PW-1:0]     msg_d;
    logic [PW-1:0]     out_d;
    logic              err_q;
    line_st_t          pq_st;

    mi_event_sel #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NODE_W(NODE_W)
    ) u_sel (
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .net_valid(net_valid), .net_type(net_type), .net_addr(net_addr),
        .net_src(net_src), .st_q(st_q), .tag_q(tag_q),
        .ev(ev), .ev_state(ev_state), .ev_slot(ev_slot), .ev_addr(ev_addr),
        .ev_src(ev_src), .ev_from_cpu(ev_from_cpu)
    );

    mi_transition u_tr (
        .ev(ev), .cur(ev_state), .nxt(tr_nxt), .send(tr_send),
        .hit(tr_hit), .err(tr_err)
    );

    assign wr_en     = (ev != EV_NONE) && !tr_err;
    assign wr_tag_en = ev_from_cpu && (ev_state == ST_I);

    mi_line_table #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(ev_slot),
        .wr_state(3'(tr_nxt)), .wr_tag_en(wr_tag_en),
        .wr_tag(ev_addr[ADDR_W-1:IDX_W]), .st_q(st_q), .tag_q(tag_q)
    );

    always_comb begin
        msg_v = (tr_send != MSG_NONE);
        msg_d = {2'(tr_send), ev_addr,
                 (tr_send == MSG_DATA) ? ev_src : NODE_W'(DIR_ID)};
    end

    mi_msg_delay #(.LAT(ISSUE_LAT), .PW(PW)) u_delay (
        .clk(clk), .rst_n(rst_n), .in_valid(msg_v), .in_data(msg_d),
        .out_valid(out_valid), .out_data(out_d)
    );

    assign out_type = out_d[PW-1 -: 2];
    assign out_addr = out_d[NODE_W +: ADDR_W];
    assign out_dest = out_d[NODE_W-1:0];
    assign out_src  = NODE_W'(REQ_ID);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (tr_err) begin
            err_q <= 1'b1;
        end
    end
    assign proto_err = err_q;

    assign cpu_ready = ev_from_cpu && tr_hit;

    always_comb begin
        pq_st = line_st_t'(st_q[perm_addr[IDX_W-1:0]]);
        if (tag_q[perm_addr[IDX_W-1:0]] == perm_addr[ADDR_W-1:IDX_W]) begin
            perm = 2'(perm_of(pq_st));
        end else begin
            perm = 2'(PERM_INVALID);
        end
    end
endmodule

// File: rtl/mi_line_ctrl_chk.sv
module mi_line_ctrl_chk #(
    parameter int ADDR_W    = 6,
    parameter int IDX_W     = 2,
    localparam int NUM_LINES = 1 << IDX_W,
    localparam int TAG_W     = ADDR_W - IDX_W
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cpu_valid,
    input logic [ADDR_W-1:0]               cpu_addr,
    input logic                            cpu_ready,
    input logic                            net_valid,
    input logic [2:0]                      net_type,
    input logic [ADDR_W-1:0]               net_addr,
    input logic                            out_valid,
    input logic [1:0]                      out_type,
    input logic                            proto_err,
    input logic [NUM_LINES-1:0][2:0]       st_q,
    input logic [NUM_LINES-1:0][TAG_W-1:0] tag_q
);
    logic [IDX_W-1:0] nidx;
    logic [IDX_W-1:0] cidx;
    logic             fill_ok;
    logic             cpu_busy;
    assign nidx = net_addr[IDX_W-1:0];
    assign cidx = cpu_addr[IDX_W-1:0];
    assign fill_ok = net_valid && net_type == 3'd0
                     && tag_q[nidx] == net_addr[ADDR_W-1:IDX_W]
                     && (st_q[nidx] == 3'(mi_pkg::ST_IS) || st_q[nidx] == 3'(mi_pkg::ST_IM));
    assign cpu_busy = cpu_valid && !net_valid
                      && st_q[cidx] != 3'(mi_pkg::ST_I) && st_q[cidx] != 3'(mi_pkg::ST_M);

    AST_READY_ONLY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (cpu_valid && !net_valid)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R11
    AST_OUT_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_type != 2'd0)); // R9
    AST_FILL_TO_M: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ok |=> (st_q[$past(nidx)] == 3'(mi_pkg::ST_M))); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |=> (st_q[$past(cidx)] == $past(st_q[cidx]))); // R6
    AST_READY_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (st_q[cidx] == 3'(mi_pkg::ST_M))); // R4
endmodule

bind mi_line_ctrl mi_line_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .net_valid(net_valid), .net_type(net_type),
    .net_addr(net_addr), .out_valid(out_valid), .out_type(out_type),
    .proto_err(proto_err), .st_q(st_q), .tag_q(tag_q)
);

// File: tb/mi_line_ctrl_tb.sv
module mi_line_ctrl_tb;
    localparam int AW = 6;
    localparam int IW = 2;
    localparam int NW = 3;
    localparam int LAT = 2;
    localparam int NL = 1 << IW;
    localparam int RID = 1;
    localparam int DID = 0;
    localparam int S_I = 0, S_II = 1, S_M = 2, S_MI = 3, S_MII = 4, S_IS = 5, S_IM = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic [1:0] cpu_op = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_ready;
    logic net_valid = 1'b0;
    logic [2:0] net_type = '0;
    logic [AW-1:0] net_addr = '0;
    logic [NW-1:0] net_src = '0;
    logic [AW-1:0] perm_addr = '0;
    logic [1:0] perm;
    logic out_valid;
    logic [1:0] out_type;
    logic [AW-1:0] out_addr;
    logic [NW-1:0] out_src;
    logic [NW-1:0] out_dest;
    logic proto_err;

    always #5 clk = ~clk;

    mi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .NODE_W(NW), .ISSUE_LAT(LAT),
                   .REQ_ID(RID), .DIR_ID(DID)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .net_valid(net_valid),
        .net_type(net_type), .net_addr(net_addr), .net_src(net_src),
        .perm_addr(perm_addr), .perm(perm), .out_valid(out_valid),
        .out_type(out_type), .out_addr(out_addr), .out_src(out_src),
        .out_dest(out_dest), .proto_err(proto_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int m_st[NL];
    int m_tag[NL];
    bit m_err;
    bit pv[LAT];
    int pt[LAT];
    int pa[LAT];
    int pd[LAT];

    task automatic chk(int act, int exp, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_perm(logic [AW-1:0] a);
        int i = int'(a[IW-1:0]);
        if (m_st[i] == S_I || m_tag[i] != int'(a[AW-1:IW])) return 0;
        if (m_st[i] == S_M) return 2;
        return 1;
    endfunction

    function automatic bit exp_ready();
        int i = int'(cpu_addr[IW-1:0]);
        return !net_valid && cpu_valid && m_st[i] == S_M && m_tag[i] == int'(cpu_addr[AW-1:IW]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin
            m_st[i] = S_I;
            m_tag[i] = 0;
        end
        m_err = 1'b0;
        for (int k = 0; k < LAT; k++) begin
            pv[k] = 1'b0; pt[k] = 0; pa[k] = 0; pd[k] = 0;
        end
    endtask

    // one clock: check at mid-cycle, predict, advance
    task automatic cycle();
        int i, s, ns, ntag, mt, ma, md;
        bit mv, bad, held;
        #1;
        chk(int'(cpu_ready), int'(exp_ready()), net_valid ? "R10" : (exp_ready() ? "R4" : "R6"));
        chk(int'(out_valid), int'(pv[LAT-1]), "R9");
        if (pv[LAT-1]) begin
            chk(int'(out_type), pt[LAT-1], "R9");
            chk(int'(out_addr), pa[LAT-1], "R9");
            chk(int'(out_dest), pd[LAT-1], "R9");
            chk(int'(out_src), RID, "R9");
        end
        chk(int'(perm), exp_perm(perm_addr), "R2");
        chk(int'(proto_err), int'(m_err), "R11");
        mv = 1'b0; mt = 0; ma = 0; md = 0; bad = 1'b0; i = 0; ns = 0; ntag = 0;
        if (net_valid) begin
            i = int'(net_addr[IW-1:0]);
            held = m_st[i] != S_I && m_tag[i] == int'(net_addr[AW-1:IW]);
            s = held ? m_st[i] : S_I;
            ns = s; ntag = m_tag[i];
            case (int'(net_type))
                0: if (s == S_IS || s == S_IM) ns = S_M; else bad = 1'b1;
                1, 2: begin
                    if (s == S_M || s == S_MII) ns = S_I;
                    else if (s == S_MI) ns = S_II;
                    else bad = 1'b1;
                    if (!bad) begin mv = 1'b1; mt = 3; ma = int'(net_addr); md = int'(net_src); end
                end
                3: if (s == S_MI || s == S_II) ns = S_I; else bad = 1'b1;
                4: if (s == S_MI) ns = S_MII; else if (s == S_II) ns = S_I; else bad = 1'b1;
                default: ns = m_st[i];
            endcase
            if (bad || int'(net_type) > 4) ns = m_st[i];
        end else if (cpu_valid) begin
            i = int'(cpu_addr[IW-1:0]);
            s = m_st[i]; ns = s; ntag = m_tag[i];
            if (s == S_I) begin
                ns = (cpu_op == 2'd2) ? S_IM : S_IS;
                ntag = int'(cpu_addr[AW-1:IW]);
                mv = 1'b1; mt = 1; ma = int'(cpu_addr); md = DID;
            end else if (s == S_M && m_tag[i] != int'(cpu_addr[AW-1:IW])) begin
                ns = S_MI;
                mv = 1'b1; mt = 2; ma = m_tag[i] * NL + i; md = DID;
            end
        end else begin
            ns = m_st[0]; ntag = m_tag[0];
        end
        @(posedge clk);
        m_st[i] = ns;
        m_tag[i] = ntag;
        if (bad) m_err = 1'b1;
        for (int k = LAT-1; k > 0; k--) begin
            pv[k] = pv[k-1]; pt[k] = pt[k-1]; pa[k] = pa[k-1]; pd[k] = pd[k-1];
        end
        pv[0] = mv; pt[0] = mt; pa[0] = ma; pd[0] = md;
        @(negedge clk);
    endtask

    task automatic drive(bit cv, int op, int ca, bit nv, int nt, int na, int ns);
        cpu_valid = cv; cpu_op = 2'(op); cpu_addr = AW'(ca);
        net_valid = nv; net_type = 3'(nt); net_addr = AW'(na); net_src = NW'(ns);
        cycle();
        cpu_valid = 1'b0; net_valid = 1'b0;
    endtask

    task automatic cpu(int op, int a);  drive(1'b1, op, a, 1'b0, 0, 0, 0); endtask
    task automatic net(int t, int a, int s); drive(1'b0, 0, 0, 1'b1, t, a, s); endtask
    task automatic idle(); drive(1'b0, 0, 0, 1'b0, 0, 0, 0); endtask

    task automatic perm_chk(int a, int exp, string tag);
        perm_addr = AW'(a);
        #1;
        chk(int'(perm), exp, tag);
    endtask

    localparam int A = 6'h04, B = 6'h05, C = 6'h08, D = 6'h06, E = 6'h0A;

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        perm_chk(A, 0, "R1");
        perm_chk(B, 0, "R1");
        chk(int'(out_valid), 0, "R1");
        chk(int'(proto_err), 0, "R1");
        chk(int'(cpu_ready), 0, "R1");
        // R3: load miss
        cpu(0, A);
        perm_chk(A, 1, "R3");
        cpu(0, A);                         // R6 stall while IS
        idle();
        net(0, A, 0);                      // R4 fill
        perm_chk(A, 2, "R4");
        cpu(0, A);                         // R4 hit
        // R10 + R12: network has priority, reserved type ignored
        drive(1'b1, 1, A, 1'b1, 6, A, 2);
        perm_chk(A, 2, "R12");
        chk(int'(proto_err), 0, "R12");
        cpu(2, B);                         // R3 store miss
        perm_chk(B, 1, "R3");
        net(0, B, 0);
        // R5: replacement on victim A
        cpu(0, C);
        perm_chk(A, 1, "R5");
        perm_chk(C, 0, "R5");
        cpu(0, C);                         // R6 stall behind MI
        net(4, A, 0);                      // R7 nack -> MII
        perm_chk(A, 1, "R7");
        net(1, A, 5);                      // R7 fwd in MII -> I with data
        perm_chk(A, 0, "R7");
        cpu(0, C);
        net(0, C, 0);
        perm_chk(C, 2, "R4");
        net(2, B, 3);                      // R8 invalidate in M
        perm_chk(B, 0, "R8");
        cpu(1, D);
        net(0, D, 0);
        cpu(0, E);                         // victim D -> MI
        net(1, D, 4);                      // R7 fwd in MI -> II
        perm_chk(D, 1, "R7");
        net(3, D, 0);                      // R7 ack in II -> I
        perm_chk(D, 0, "R7");
        idle(); idle(); idle();
        chk(int'(proto_err), 0, "R11");
        net(0, B, 0);                      // R11 data to a line not held
        idle();
        chk(int'(proto_err), 1, "R11");
        idle();
        chk(int'(proto_err), 1, "R11");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int ti, tt, ca, na, ty;
            ti = int'($urandom % NL);
            tt = 1 + int'($urandom % 2);
            ca = tt * NL + ti;
            ti = int'($urandom % NL);
            if (($urandom % 5) != 0) na = m_tag[ti] * NL + ti;
            else na = (1 + int'($urandom % 2)) * NL + ti;
            ty = int'($urandom % 6);
            if (ty == 5) ty = 6;
            perm_addr = AW'($urandom);
            drive(($urandom % 10) < 6, int'($urandom % 4), ca,
                  ($urandom % 10) < 3, ty, na, int'($urandom % 8));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule